// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block walks an analog-to-digital converter through a table of conversion command words. Each word names an input channel (six bits by default) and carries a pause bit. The table is shared by two queues. The first queue always begins at entry 0. The second begins at a base pointer held in a register one bit wider than the table index, so the pointer can also name positions past the last entry. A trigger pulse on a queue starts it from its beginning, or resumes it after a pause. The sequencer then issues one start pulse per command to an external converter and waits for that converter's done pulse before moving to the next entry.

A queue stops at the first end condition it meets. The end conditions are:

- a command whose channel field is all ones (the end code);
- for the first queue, reaching the second queue's base;
- stepping past the last table entry;
- a second-queue base that already lies beyond the table.

A pause bit splits a queue into sub-queues: after the paused conversion the queue waits for its next trigger. When a pause is immediately followed by an end condition, the end condition wins and the queue goes idle. Each queue has a sticky pause flag and a sticky completion flag, cleared by writing 1. Each flag has an interrupt output gated by an enable bit.

Top module: `adc_queue_seq`

## Requirements
- R1: A command written through the table write port (address, channel, pause bit) is the one used when its entry executes; its channel appears on `conv_chan`.
- R2: A trigger on an idle queue starts it at its first entry (entry 0 for queue 1, `q2_base` for queue 2). Each command produces a `conv_start` pulse exactly one cycle long, and the index advances only after `conv_done`.
- R3: A command whose channel field equals the all-ones end code produces no conversion. The running queue sets its completion flag and its status returns to idle (00); this also holds for the very first command read.
- R4: Queue 1 executes entries 0 up to `q2_base`-1. With `q2_base` = 0, a queue-1 trigger completes with no conversion.
- R5: With `q2_base` equal to the last entry, a queue-2 trigger converts that entry, then completes and goes idle.
- R6: With `q2_base` above the last entry index, a queue-2 trigger completes with no conversion.
- R7: After converting a command whose pause bit is set, the queue sets its pause flag and its status becomes paused (10). The next trigger on that queue resumes at the following entry.
- R8: When a paused command is followed by any end condition, both the pause flag and the completion flag are set and the status is idle, not paused.
- R9: Queue status is 00 idle, 01 active, 10 paused, and at most one queue is active at a time. Triggers arriving while a queue is active are ignored. When both triggers arrive in the same cycle, queue 1 starts.
- R10: Flags stay set until a 1 is written to their clear bit. Each interrupt output equals its flag ANDed with its enable bit. Only the queue that ran gets its flags set.
- R11: After reset both queues are idle, all flags are 0 and `conv_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_q1 | input | 1 | Queue 1 trigger pulse |
| trig_q2 | input | 1 | Queue 2 trigger pulse |
| ccw_we | input | 1 | Table write strobe |
| ccw_waddr | input | 6 | Table entry to write |
| ccw_wchan | input | 6 | Channel field written |
| ccw_wpause | input | 1 | Pause bit written |
| q2_base | input | 7 | Queue 2 base pointer (values 64..127 lie past the table) |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 6 | Channel for the current conversion |
| conv_done | input | 1 | Converter finished the current conversion |
| flag_clr_pause | input | 2 | Write-1 clear of pause flags (bit 0 = queue 1) |
| flag_clr_cmpl | input | 2 | Write-1 clear of completion flags |
| irq_en_pause | input | 2 | Pause interrupt enables |
| irq_en_cmpl | input | 2 | Completion interrupt enables |
| pause_flag | output | 2 | Sticky pause flags |
| cmpl_flag | output | 2 | Sticky completion flags |
| q1_status | output | 2 | Queue 1 status |
| q2_status | output | 2 | Queue 2 status |
| irq_pause | output | 2 | Pause interrupts |
| irq_cmpl | output | 2 | Completion interrupts |

## Verification
A corrupted table index shows up on `conv_chan` at the next start pulse, one fetch cycle after the previous `conv_done`. It also shows up at the end of a sub-queue as a wrong conversion count. A wrong saved resume pointer appears only at the trigger after a pause, so each pause scenario is followed by its resuming trigger. Faults in end-condition precedence leave a queue paused instead of idle, or leave a spurious flag on the other queue, within one cycle of the last done.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

   typedef enum logic [1:0] {
      QS_IDLE   = 2'b00,
      QS_ACTIVE = 2'b01,
      QS_PAUSED = 2'b10
   } qstat_e;

   typedef enum logic [1:0] {
      EN_IDLE  = 2'b00,
      EN_FETCH = 2'b01,
      EN_WAIT  = 2'b10
   } eng_state_e;

   localparam int NUM_Q = 2;

endpackage

// File: rtl/qseq_ccw_table.sv
module qseq_ccw_table #(
   parameter int CHAN_W = 6,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              we,
   input  logic [CHAN_W-1:0] waddr,
   input  logic [CHAN_W-1:0] wchan,
   input  logic              wpause,
   input  logic [CHAN_W-1:0] raddr,
   output logic [CHAN_W-1:0] rchan,
   output logic              rpause
);
   localparam int ENT_W = CHAN_W + 1;

   generate
      if (DEPTH != (1 << CHAN_W)) begin : g_bad_depth
         $error("qseq_ccw_table: DEPTH must equal 2**CHAN_W");
      end
   endgenerate

   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= {wpause, wchan};
   end

   assign rchan  = mem[raddr][CHAN_W-1:0];
   assign rpause = mem[raddr][CHAN_W];

endmodule

// File: rtl/qseq_engine.sv
module qseq_engine
   import qseq_pkg::*;
#(
   parameter int CHAN_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_q1,
   input  logic              trig_q2,
   input  logic [CHAN_W:0]   q2_base,
   output logic [CHAN_W-1:0] rd_addr,
   input  logic [CHAN_W-1:0] rd_chan,
   input  logic              rd_pause,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   output logic [NUM_Q-1:0]  set_pause,
   output logic [NUM_Q-1:0]  set_cmpl,
   output qstat_e            stat_q1,
   output qstat_e            stat_q2
);
   localparam int PTR_W = CHAN_W + 1;
   localparam logic [CHAN_W-1:0] END_CODE = {CHAN_W{1'b1}};

   eng_state_e       state;
   logic             cur_q;
   logic [PTR_W-1:0] ptr;
   logic [PTR_W-1:0] resume [NUM_Q];
   qstat_e           stat [NUM_Q];
   logic             pend_pause;
   logic             cur_pause;
   logic             eoq;
   logic             go_q1, go_q2;

   assign rd_addr = ptr[CHAN_W-1:0];
   assign stat_q1 = stat[0];
   assign stat_q2 = stat[1];

   // end of queue: past table, queue-1 reached queue-2 base, or end code
   always_comb begin
      eoq = ptr[CHAN_W]
          | ((cur_q == 1'b0) && (ptr == q2_base))
          | (rd_chan == END_CODE);
   end

   assign go_q1 = (state == EN_IDLE) && trig_q1;
   assign go_q2 = (state == EN_IDLE) && trig_q2 && !trig_q1;

   always_comb begin
      set_pause = '0;
      set_cmpl  = '0;
      if (state == EN_FETCH) begin
         if (eoq) begin
            set_cmpl[cur_q]  = 1'b1;
            set_pause[cur_q] = pend_pause;
         end else if (pend_pause) begin
            set_pause[cur_q] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= EN_IDLE;
         cur_q      <= 1'b0;
         ptr        <= '0;
         pend_pause <= 1'b0;
         cur_pause  <= 1'b0;
         conv_start <= 1'b0;
         conv_chan  <= '0;
         for (int i = 0; i < NUM_Q; i++) begin
            resume[i] <= '0;
            stat[i]   <= QS_IDLE;
         end
      end else begin
         conv_start <= 1'b0;
         unique case (state)
            EN_IDLE: begin
               if (go_q1) begin
                  cur_q   <= 1'b0;
                  ptr     <= (stat[0] == QS_PAUSED) ? resume[0] : '0;
                  stat[0] <= QS_ACTIVE;
                  state   <= EN_FETCH;
               end else if (go_q2) begin
                  cur_q   <= 1'b1;
                  ptr     <= (stat[1] == QS_PAUSED) ? resume[1] : q2_base;
                  stat[1] <= QS_ACTIVE;
                  state   <= EN_FETCH;
               end
            end
            EN_FETCH: begin
               pend_pause <= 1'b0;
               if (eoq) begin
                  stat[cur_q] <= QS_IDLE;
                  state       <= EN_IDLE;
               end else if (pend_pause) begin
                  stat[cur_q]   <= QS_PAUSED;
                  resume[cur_q] <= ptr;
                  state         <= EN_IDLE;
               end else begin
                  conv_start <= 1'b1;
                  conv_chan  <= rd_chan;
                  cur_pause  <= rd_pause;
                  state      <= EN_WAIT;
               end
            end
            EN_WAIT: begin
               if (conv_done) begin
                  ptr        <= ptr + 1'b1;
                  pend_pause <= cur_pause;
                  state      <= EN_FETCH;
               end
            end
            default: state <= EN_IDLE;
         endcase
      end
   end

   // R2: start is a single-cycle pulse
   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R3: an end condition at fetch never launches a conversion
   p_eoq_no_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == EN_FETCH && eoq) |=> !conv_start);

   // R9: never two queues active
   p_single_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stat[0] == QS_ACTIVE, stat[1] == QS_ACTIVE}));

   // R9: status encoding stays legal
   p_stat_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[0] != 2'b11) && (stat[1] != 2'b11));

   // R8: a completing queue never ends up paused
   p_cmpl_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_cmpl[0] |=> (stat[0] == QS_IDLE));

endmodule

// File: rtl/qseq_flags.sv
module qseq_flags
   import qseq_pkg::*;
#(
   parameter bit IRQ_PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_Q-1:0] set_pause,
   input  logic [NUM_Q-1:0] set_cmpl,
   input  logic [NUM_Q-1:0] clr_pause,
   input  logic [NUM_Q-1:0] clr_cmpl,
   input  logic [NUM_Q-1:0] en_pause,
   input  logic [NUM_Q-1:0] en_cmpl,
   output logic [NUM_Q-1:0] pause_flag,
   output logic [NUM_Q-1:0] cmpl_flag,
   output logic [NUM_Q-1:0] irq_pause,
   output logic [NUM_Q-1:0] irq_cmpl
);

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pause_flag[q] <= 1'b0;
            cmpl_flag[q]  <= 1'b0;
         end else begin
            // a set in the same cycle as a clear wins
            if (set_pause[q])      pause_flag[q] <= 1'b1;
            else if (clr_pause[q]) pause_flag[q] <= 1'b0;
            if (set_cmpl[q])       cmpl_flag[q]  <= 1'b1;
            else if (clr_cmpl[q])  cmpl_flag[q]  <= 1'b0;
         end
      end

      if (IRQ_PRESENT) begin : g_irq
         assign irq_pause[q] = pause_flag[q] & en_pause[q];
         assign irq_cmpl[q]  = cmpl_flag[q] & en_cmpl[q];
      end else begin : g_noirq
         assign irq_pause[q] = 1'b0;
         assign irq_cmpl[q]  = 1'b0;
      end

      // R10: flags are sticky without a clear
      p_sticky_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (pause_flag[q] && !clr_pause[q]) |=> pause_flag[q]);
      p_sticky_cmpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (cmpl_flag[q] && !clr_cmpl[q]) |=> cmpl_flag[q]);
   end

endmodule

// File: rtl/adc_queue_seq.sv
module adc_queue_seq
   import qseq_pkg::*;
#(
   parameter int CHAN_W      = 6,
   parameter bit IRQ_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_q1,
   input  logic              trig_q2,
   input  logic              ccw_we,
   input  logic [CHAN_W-1:0] ccw_waddr,
   input  logic [CHAN_W-1:0] ccw_wchan,
   input  logic              ccw_wpause,
   input  logic [CHAN_W:0]   q2_base,
   output logic              conv_start,
   output logic [CHAN_W-1:0] conv_chan,
   input  logic              conv_done,
   input  logic [1:0]        flag_clr_pause,
   input  logic [1:0]        flag_clr_cmpl,
   input  logic [1:0]        irq_en_pause,
   input  logic [1:0]        irq_en_cmpl,
   output logic [1:0]        pause_flag,
   output logic [1:0]        cmpl_flag,
   output logic [1:0]        q1_status,
   output logic [1:0]        q2_status,
   output logic [1:0]        irq_pause,
   output logic [1:0]        irq_cmpl
);
   localparam int DEPTH = 1 << CHAN_W;

   generate
      if (CHAN_W < 2 || CHAN_W > 8) begin : g_bad_w
         $error("adc_queue_seq: CHAN_W out of range 2..8");
      end
   endgenerate

   logic [CHAN_W-1:0] rd_addr, rd_chan;
   logic              rd_pause;
   logic [NUM_Q-1:0]  set_pause, set_cmpl;
   qstat_e            st1, st2;

   qseq_ccw_table #(.CHAN_W(CHAN_W), .DEPTH(DEPTH)) u_table (
      .clk(clk), .we(ccw_we), .waddr(ccw_waddr), .wchan(ccw_wchan),
      .wpause(ccw_wpause), .raddr(rd_addr), .rchan(rd_chan), .rpause(rd_pause)
   );

   qseq_engine #(.CHAN_W(CHAN_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .trig_q1(trig_q1), .trig_q2(trig_q2),
      .q2_base(q2_base), .rd_addr(rd_addr), .rd_chan(rd_chan),
      .rd_pause(rd_pause), .conv_start(conv_start), .conv_chan(conv_chan),
      .conv_done(conv_done), .set_pause(set_pause), .set_cmpl(set_cmpl),
      .stat_q1(st1), .stat_q2(st2)
   );

   qseq_flags #(.IRQ_PRESENT(IRQ_PRESENT)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_pause(set_pause), .set_cmpl(set_cmpl),
      .clr_pause(flag_clr_pause), .clr_cmpl(flag_clr_cmpl),
      .en_pause(irq_en_pause), .en_cmpl(irq_en_cmpl),
      .pause_flag(pause_flag), .cmpl_flag(cmpl_flag),
      .irq_pause(irq_pause), .irq_cmpl(irq_cmpl)
   );

   assign q1_status = st1;
   assign q2_status = st2;

   // R11: converter stays quiet while both queues idle
   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (q1_status != 2'b01 && q2_status != 2'b01) |-> !conv_start);

endmodule

// File: tb/sim_adc_queue_seq.sv
module sim_adc_queue_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_q1 = 1'b0, trig_q2 = 1'b0;
   logic       ccw_we = 1'b0;
   logic [5:0] ccw_waddr = '0, ccw_wchan = '0;
   logic       ccw_wpause = 1'b0;
   logic [6:0] q2_base = '0;
   logic       conv_start;
   logic [5:0] conv_chan;
   logic       conv_done;
   logic [1:0] clr_p = '0, clr_c = '0, en_p = '0, en_c = '0;
   logic [1:0] pause_flag, cmpl_flag, q1_status, q2_status, irq_pause, irq_cmpl;

   int n_checks = 0, n_fail = 0, n_conv = 0;
   logic [5:0] last_chan = '0;
   logic d1 = 1'b0, d2 = 1'b0;
   bit done_all = 0;

   always #5 clk = ~clk;

   adc_queue_seq u0 (
      .clk(clk), .rst_n(rst_n), .trig_q1(trig_q1), .trig_q2(trig_q2),
      .ccw_we(ccw_we), .ccw_waddr(ccw_waddr), .ccw_wchan(ccw_wchan),
      .ccw_wpause(ccw_wpause), .q2_base(q2_base), .conv_start(conv_start),
      .conv_chan(conv_chan), .conv_done(conv_done),
      .flag_clr_pause(clr_p), .flag_clr_cmpl(clr_c),
      .irq_en_pause(en_p), .irq_en_cmpl(en_c),
      .pause_flag(pause_flag), .cmpl_flag(cmpl_flag),
      .q1_status(q1_status), .q2_status(q2_status),
      .irq_pause(irq_pause), .irq_cmpl(irq_cmpl)
   );

   // converter model: done two cycles after start
   always @(posedge clk) begin
      d1 <= conv_start;
      d2 <= d1;
      if (rst_n && conv_start) begin
         n_conv    <= n_conv + 1;
         last_chan <= conv_chan;
      end
   end
   assign conv_done = d2;

   typedef struct packed {
      logic       q;      // 0 = queue 1, 1 = queue 2
      logic [6:0] base;
      logic [7:0] nconv;
      logic [5:0] last;
      logic       pf;
      logic       cf;
      logic [1:0] st;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 7'd20,  8'd3,  6'd2,  1'b1, 1'b0, 2'b10},  // R7 pause at 2
      '{1'b0, 7'd20,  8'd17, 6'd19, 1'b0, 1'b1, 2'b00},  // R7 resume, R4 stop at base
      '{1'b1, 7'd20,  8'd20, 6'd39, 1'b0, 1'b1, 2'b00},  // R2 q2 start, R3 end code
      '{1'b1, 7'd41,  8'd5,  6'd45, 1'b1, 1'b0, 2'b10},  // R7 q2 pause
      '{1'b1, 7'd41,  8'd5,  6'd50, 1'b1, 1'b1, 2'b00},  // R8 pause then end code
      '{1'b1, 7'd63,  8'd1,  6'd5,  1'b1, 1'b1, 2'b00},  // R5, R8 pause on last entry
      '{1'b1, 7'd64,  8'd0,  6'd0,  1'b0, 1'b1, 2'b00},  // R6
      '{1'b1, 7'd100, 8'd0,  6'd0,  1'b0, 1'b1, 2'b00},  // R6
      '{1'b0, 7'd0,   8'd0,  6'd0,  1'b0, 1'b1, 2'b00},  // R4 base zero
      '{1'b1, 7'd40,  8'd0,  6'd0,  1'b0, 1'b1, 2'b00},  // R3 first entry end code
      '{1'b0, 7'd127, 8'd3,  6'd2,  1'b1, 1'b0, 2'b10},  // R7
      '{1'b0, 7'd127, 8'd37, 6'd39, 1'b0, 1'b1, 2'b00}   // R3 end code in q1
   };

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_ccw(input int a, input int ch, input bit p);
      @(negedge clk);
      ccw_we = 1'b1; ccw_waddr = a[5:0]; ccw_wchan = ch[5:0]; ccw_wpause = p;
      @(negedge clk);
      ccw_we = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk);
      clr_p = 2'b11; clr_c = 2'b11;
      @(negedge clk);
      clr_p = 2'b00; clr_c = 2'b00;
   endtask

   task automatic pulse(input bit t1, input bit t2);
      @(negedge clk);
      trig_q1 = t1; trig_q2 = t2;
      @(negedge clk);
      trig_q1 = 1'b0; trig_q2 = 1'b0;
   endtask

   task automatic wait_stop(input bit q);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if ((q ? q2_status : q1_status) != 2'b01) break;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #1500000;
      if (!done_all) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 q1_status", q1_status, 0);
      check("R11 q2_status", q2_status, 0);
      check("R11 flags", {pause_flag, cmpl_flag}, 0);
      check("R11 conv_start", conv_start, 0);
      rst_n = 1'b1;

      // R1 load table: chan = index, with end codes, pauses
      for (int i = 0; i < 64; i++) begin
         int ch;
         ch = (i == 40 || i == 51) ? 63 : (i == 63 ? 5 : i);
         wr_ccw(i, ch, (i == 2 || i == 45 || i == 50 || i == 63));
      end

      for (int v = 0; v < NV; v++) begin
         int c0;
         clear_flags();
         q2_base = VEC[v].base;
         c0 = n_conv;
         pulse(!VEC[v].q, VEC[v].q);
         wait_stop(VEC[v].q);
         check($sformatf("R2/R3/R4/R6 v%0d conversions", v), n_conv - c0, VEC[v].nconv);
         if (VEC[v].nconv != 0)
            check($sformatf("R1/R5 v%0d last channel", v), last_chan, VEC[v].last);
         check($sformatf("R7/R8 v%0d pause flag", v), pause_flag[VEC[v].q], VEC[v].pf);
         check($sformatf("R3/R8 v%0d cmpl flag", v), cmpl_flag[VEC[v].q], VEC[v].cf);
         check($sformatf("R10 v%0d other queue flags", v),
               {pause_flag[!VEC[v].q], cmpl_flag[!VEC[v].q]}, 0);
         check($sformatf("R7/R9 v%0d status", v),
               VEC[v].q ? q2_status : q1_status, VEC[v].st);
      end

      // R1 rewrite an entry and see it used
      wr_ccw(0, 33, 1'b0);
      clear_flags();
      q2_base = 7'd1;
      pulse(1'b1, 1'b0);
      wait_stop(1'b0);
      check("R1 rewritten channel", last_chan, 33);
      check("R4 cmpl after base", cmpl_flag[0], 1);

      // R9 simultaneous triggers: queue 1 wins; q2 ignored while q1 active
      clear_flags();
      q2_base = 7'd20;
      begin
         int c0;
         c0 = n_conv;
         pulse(1'b1, 1'b1);
         check("R9 q1 active", q1_status, 1);
         check("R9 q2 idle", q2_status, 0);
         pulse(1'b0, 1'b1);
         check("R9 q2 ignored", q2_status, 0);
         wait_stop(1'b0);
         check("R9 q1 paused at 2", q1_status, 2);
         check("R9 q1 convs", n_conv - c0, 3);
         check("R9 q2 untouched", {pause_flag[1], cmpl_flag[1], q2_status}, 0);
      end

      // R10 interrupt gating and write-1 clear
      check("R10 irq off", irq_pause[0], 0);
      @(negedge clk); en_p = 2'b01;
      @(negedge clk);
      check("R10 irq on", irq_pause[0], 1);
      check("R10 cmpl irq off", irq_cmpl, 0);
      @(negedge clk); clr_p = 2'b01;
      @(negedge clk); clr_p = 2'b00;
      check("R10 flag cleared", pause_flag[0], 0);
      check("R10 irq cleared", irq_pause[0], 0);

      done_all = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule